// File: doc/BRIEF.md
# Arm Submodule Insertion Selector

This block picks which capacitor submodules of one converter arm are switched into the current path for the next update period. Each request carries the number of modules to insert, the direction of the arm current, the capacitor voltage of every module, a nominal capacitor voltage and a flag that enables band-hold mode. The block ranks the modules by charge, with the order set by the current direction, and returns an insertion mask with one bit per module. When the current discharges the capacitors, the fullest modules are inserted. When it charges them, the emptiest ones are.

In band-hold mode the previous mask stays in place as long as every capacitor lies inside a band around the nominal voltage. A change in the requested count then only adds or removes modules, starting from the previous set. This cuts the number of switching events. As soon as any capacitor leaves the band, the arm is re-ranked from scratch.

Requests enter through a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while a ranking is in progress, and a source holding `req_valid` high simply waits. The mask output has no back-pressure. It is a level that holds its value for the gate logic, and `mask_valid` marks that it belongs to the latest accepted request.

Top module: `arm_insert_selector`

## Requirements
- R1: During reset `sel_mask` is all zero, `mask_valid` is low and `req_ready` is high, and a reset in the middle of a ranking returns the block to that state.
- R2: A request is taken only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from the edge after acceptance until the result is out, and inputs presented during that time have no effect on the result.
- R3: The new mask and a high `mask_valid` appear exactly N_MOD clock edges after the accepting edge. `mask_valid` is low in between, and `sel_mask` keeps its previous value until then.
- R4: With `req_discharge` = 1, the inserted modules are those with the highest voltages. Bit i of `sel_mask` is module i, whose voltage is `req_volts[i*VW +: VW]`.
- R5: With `req_discharge` = 0, the inserted modules are those with the lowest voltages.
- R6: Between equal voltages, the module with the lower index has priority.
- R7: `sel_mask` has exactly min(`req_count`, N_MOD) bits set.
- R8: With `req_band_en` = 1, all voltages inside the inclusive band from nom − nom/10 to nom + nom/10 (integer division), and an unchanged count, the previous mask is kept whatever the current direction.
- R9: In band-hold mode with a larger count, every previously inserted module stays, and the extra modules come from the non-inserted ones in priority order.
- R10: In band-hold mode with a smaller count, only previously inserted modules remain, and the ones with the higher priority are kept.
- R11: With `req_band_en` = 0, or with any voltage outside the band, the mask comes from a full ranking of all modules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_count | input | CW | Requested number of inserted modules |
| req_discharge | input | 1 | 1: arm current discharges the capacitors; 0: it charges them |
| req_band_en | input | 1 | Enable band-hold mode |
| req_volts | input | N_MOD*VW | Capacitor voltages, module i at bits i*VW +: VW |
| nom_volt | input | VW | Nominal capacitor voltage |
| sel_mask | output | N_MOD | Insertion mask, bit i for module i |
| mask_valid | output | 1 | Mask matches the latest accepted request |

## Verification
Everything the block computes is due on the N_MOD-th rising edge after the accepting edge. The bench drives and samples on falling edges only. For each request it checks the signals three times: half a cycle after acceptance (ready low, old mask held), half a cycle after edge N_MOD−1 (still not valid), and half a cycle after edge N_MOD (new mask valid). The vector table runs in order, so each band-hold vector starts from the mask the previous vector left behind.

// File: rtl/ais_pkg.sv
package ais_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RANK = 1'b1
  } ais_state_t;

  // band half-width is nominal / BAND_DIV
  localparam int BAND_DIV = 10;
endpackage

// File: rtl/ais_popcount.sv
module ais_popcount #(
  parameter int N_BITS = 6,
  parameter int CW     = $clog2(N_BITS + 1)
) (
  input  logic [N_BITS-1:0] bits,
  output logic [CW-1:0]     count
);
  always_comb begin
    count = '0;
    for (int k = 0; k < N_BITS; k++) begin
      count = count + CW'(bits[k]);
    end
  end
endmodule

// File: rtl/ais_band_check.sv
module ais_band_check
  import ais_pkg::*;
#(
  parameter int N_MOD = 6,
  parameter int VW    = 12
) (
  input  logic [N_MOD*VW-1:0] volts,
  input  logic [VW-1:0]       nom,
  output logic                out_of_band
);
  logic [VW-1:0] margin;
  logic [VW:0]   hi_edge;
  logic [VW-1:0] lo_edge;
  logic [N_MOD-1:0] outside;

  assign margin  = VW'(nom / BAND_DIV);
  assign hi_edge = {1'b0, nom} + {1'b0, margin};
  assign lo_edge = nom - margin;

  for (genvar g = 0; g < N_MOD; g++) begin : g_cmp
    logic [VW-1:0] v;
    assign v          = volts[g*VW +: VW];
    assign outside[g] = ({1'b0, v} > hi_edge) || (v < lo_edge);
  end

  assign out_of_band = |outside;
endmodule

// File: rtl/ais_rank_cell.sv
module ais_rank_cell #(
  parameter int N_MOD = 6,
  parameter int VW    = 12,
  parameter int IW    = (N_MOD > 1) ? $clog2(N_MOD) : 1,
  parameter int CW    = $clog2(N_MOD + 1)
) (
  input  logic [N_MOD*VW-1:0] volts,
  input  logic [IW-1:0]       target,
  input  logic                discharge,
  input  logic                keep_mode,
  input  logic [N_MOD-1:0]    prev_mask,
  output logic [CW-1:0]       rank
);
  logic [VW-1:0]    v_tgt;
  logic [N_MOD-1:0] ahead;

  assign v_tgt = volts[target*VW +: VW];

  for (genvar g = 0; g < N_MOD; g++) begin : g_cmp
    logic [VW-1:0] v_o;
    logic          same_grp;
    logic          lower_idx;
    logic          wins;
    assign v_o       = volts[g*VW +: VW];
    assign same_grp  = !keep_mode || (prev_mask[g] == prev_mask[target]);
    assign lower_idx = IW'(g) < target;
    assign wins      = discharge ? ((v_o > v_tgt) || ((v_o == v_tgt) && lower_idx))
                                 : ((v_o < v_tgt) || ((v_o == v_tgt) && lower_idx));
    assign ahead[g]  = (IW'(g) != target) && same_grp && wins;
  end

  ais_popcount #(.N_BITS(N_MOD), .CW(CW)) u_cnt (
    .bits  (ahead),
    .count (rank)
  );
endmodule

// File: rtl/arm_insert_selector.sv
module arm_insert_selector
  import ais_pkg::*;
#(
  parameter int N_MOD = 6,
  parameter int VW    = 12,
  localparam int CW   = $clog2(N_MOD + 1),
  localparam int IW   = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [CW-1:0]       req_count,
  input  logic                req_discharge,
  input  logic                req_band_en,
  input  logic [N_MOD*VW-1:0] req_volts,
  input  logic [VW-1:0]       nom_volt,
  output logic [N_MOD-1:0]    sel_mask,
  output logic                mask_valid
);
  localparam logic [IW-1:0] LAST_IDX = IW'(N_MOD - 1);
  localparam logic [CW-1:0] MAX_CNT  = CW'(N_MOD);

  ais_state_t          state_q;
  logic [IW-1:0]       idx_q;
  logic [N_MOD*VW-1:0] volts_q;
  logic [VW-1:0]       nom_q;
  logic [CW-1:0]       cnt_q;
  logic                dis_q;
  logic                band_q;
  logic [N_MOD-1:0]    work_q;

  logic                oob;
  logic                keep_mode;
  logic [CW-1:0]       prev_cnt;
  logic [CW-1:0]       grank;
  logic [CW-1:0]       thr;
  logic                pick;
  logic [N_MOD-1:0]    work_nx;
  logic                accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  ais_band_check #(.N_MOD(N_MOD), .VW(VW)) u_band (
    .volts       (volts_q),
    .nom         (nom_q),
    .out_of_band (oob)
  );

  // hold the previous set only while every capacitor stays in band
  assign keep_mode = band_q && !oob;

  ais_popcount #(.N_BITS(N_MOD), .CW(CW)) u_prev (
    .bits  (sel_mask),
    .count (prev_cnt)
  );

  ais_rank_cell #(.N_MOD(N_MOD), .VW(VW), .IW(IW), .CW(CW)) u_rank (
    .volts     (volts_q),
    .target    (idx_q),
    .discharge (dis_q),
    .keep_mode (keep_mode),
    .prev_mask (sel_mask),
    .rank      (grank)
  );

  // inserted modules compete for the new count; idle ones only for the increase
  always_comb begin
    if (!keep_mode || sel_mask[idx_q]) begin
      thr = cnt_q;
    end else if (cnt_q > prev_cnt) begin
      thr = cnt_q - prev_cnt;
    end else begin
      thr = '0;
    end
  end

  assign pick = grank < thr;

  always_comb begin
    work_nx        = work_q;
    work_nx[idx_q] = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      volts_q    <= '0;
      nom_q      <= '0;
      cnt_q      <= '0;
      dis_q      <= 1'b0;
      band_q     <= 1'b0;
      work_q     <= '0;
      sel_mask   <= '0;
      mask_valid <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            volts_q    <= req_volts;
            nom_q      <= nom_volt;
            cnt_q      <= (req_count > MAX_CNT) ? MAX_CNT : req_count;
            dis_q      <= req_discharge;
            band_q     <= req_band_en;
            idx_q      <= '0;
            work_q     <= '0;
            mask_valid <= 1'b0;
            state_q    <= ST_RANK;
          end
        end
        ST_RANK: begin
          work_q <= work_nx;
          if (idx_q == LAST_IDX) begin
            sel_mask   <= work_nx;
            mask_valid <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/arm_insert_selector_chk.sv
module arm_insert_selector_chk #(
  parameter int N_MOD = 6,
  localparam int CW   = $clog2(N_MOD + 1),
  localparam int TW   = $clog2(N_MOD + 2) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CW-1:0]    req_count,
  input logic [N_MOD-1:0] sel_mask,
  input logic             mask_valid
);
  logic [CW-1:0] want_q;
  logic [TW-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= '0;
      age_q  <= '0;
    end else if (req_valid && req_ready) begin
      want_q <= (req_count > CW'(N_MOD)) ? CW'(N_MOD) : req_count;
      age_q  <= TW'(1);
    end else if (age_q != '0 && !mask_valid) begin
      age_q <= age_q + TW'(1);
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !mask_valid));

  // R3
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_valid) |-> (age_q == TW'(N_MOD + 1)));

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_mask) |-> $rose(mask_valid));

  // R7
  insert_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_valid) |-> ($countones(sel_mask) == int'(want_q)));
endmodule

bind arm_insert_selector arm_insert_selector_chk #(.N_MOD(N_MOD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_count  (req_count),
  .sel_mask   (sel_mask),
  .mask_valid (mask_valid)
);

// File: tb/test_arm_insert_selector.sv
`timescale 1ns/1ps
module test_arm_insert_selector;
  localparam int N  = 6;
  localparam int VW = 12;
  localparam int CW = $clog2(N + 1);

  typedef struct packed {
    logic [CW-1:0]   cnt;
    logic            dis;
    logic            band;
    logic [N*VW-1:0] volts;
    logic [N-1:0]    exp;
  } vec_t;

  // module 0 at the low end
  localparam logic [N*VW-1:0] VA = {12'd1010, 12'd990, 12'd1020, 12'd980, 12'd1050, 12'd1000};
  localparam logic [N*VW-1:0] VT = {6{12'd1000}};
  localparam logic [N*VW-1:0] VO = {12'd1010, 12'd890, 12'd1020, 12'd980, 12'd1050, 12'd1000};
  localparam logic [N*VW-1:0] VE = {12'd1010, 12'd990, 12'd1020, 12'd980, 12'd1100, 12'd1000};
  localparam logic [N*VW-1:0] VX = {12'd1010, 12'd990, 12'd1020, 12'd980, 12'd1101, 12'd1000};

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 1'b1, 1'b0, VA, 6'h2A},  // R4 fullest three
    '{3'd3, 1'b0, 1'b0, VA, 6'h15},  // R5 emptiest three
    '{3'd2, 1'b1, 1'b0, VT, 6'h03},  // R6 ties, discharge
    '{3'd4, 1'b0, 1'b0, VT, 6'h0F},  // R6 ties, charge
    '{3'd0, 1'b1, 1'b0, VA, 6'h00},  // R7 none
    '{3'd6, 1'b1, 1'b0, VA, 6'h3F},  // R7 all
    '{3'd7, 1'b0, 1'b0, VA, 6'h3F},  // R7 clamp
    '{3'd3, 1'b1, 1'b0, VA, 6'h2A},  // R11 band off
    '{3'd3, 1'b0, 1'b1, VA, 6'h2A},  // R8 hold
    '{3'd4, 1'b1, 1'b1, VA, 6'h2B},  // R9 add one
    '{3'd2, 1'b0, 1'b1, VA, 6'h21},  // R10 drop two
    '{3'd2, 1'b1, 1'b1, VO, 6'h0A},  // R11 below band
    '{3'd2, 1'b0, 1'b1, VE, 6'h0A},  // R8 on upper edge
    '{3'd2, 1'b0, 1'b1, VX, 6'h14},  // R11 above band
    '{3'd0, 1'b1, 1'b1, VA, 6'h00}   // R10 drop all
  };
  string tags [NV] = '{"R4", "R5", "R6", "R6", "R7", "R7", "R7", "R11",
                       "R8", "R9", "R10", "R11", "R8", "R11", "R10"};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [CW-1:0]   req_count = '0;
  logic            req_discharge = 1'b0;
  logic            req_band_en = 1'b0;
  logic [N*VW-1:0] req_volts = '0;
  logic [VW-1:0]   nom_volt = 12'd1000;
  logic [N-1:0]    sel_mask;
  logic            mask_valid;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  logic [N-1:0] last_mask = '0;

  always #2 clk = ~clk;

  arm_insert_selector #(.N_MOD(N), .VW(VW)) i_arm_insert_selector (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_count     (req_count),
    .req_discharge (req_discharge),
    .req_band_en   (req_band_en),
    .req_volts     (req_volts),
    .nom_volt      (nom_volt),
    .sel_mask      (sel_mask),
    .mask_valid    (mask_valid)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [CW-1:0] c, input logic d, input logic b,
                       input logic [N*VW-1:0] v);
    req_count     = c;
    req_discharge = d;
    req_band_en   = b;
    req_volts     = v;
    req_valid     = 1'b1;
  endtask

  // called at a falling edge with the block idle
  task automatic run_req(input logic [CW-1:0] c, input logic d, input logic b,
                         input logic [N*VW-1:0] v, input logic [N-1:0] exp,
                         input string tag);
    drive(c, d, b, v);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "ready after accept", 32'(req_ready), 32'd0);
    check("R3", "held mask", 32'(sel_mask), 32'(last_mask));
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    check("R3", "valid before due", 32'(mask_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R3", "valid when due", 32'(mask_valid), 32'd1);
    check(tag, "mask", 32'(sel_mask), 32'(exp));
    last_mask = exp;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset mask", 32'(sel_mask), 32'd0);
    check("R1", "reset valid", 32'(mask_valid), 32'd0);
    check("R1", "reset ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_req(VECS[i].cnt, VECS[i].dis, VECS[i].band, VECS[i].volts, VECS[i].exp, tags[i]);
    end

    // R2: a second request held on the input while busy must wait
    drive(3'd3, 1'b1, 1'b0, VA);
    @(posedge clk);
    @(negedge clk);
    drive(3'd1, 1'b0, 1'b0, VA);
    check("R2", "ready while busy", 32'(req_ready), 32'd0);
    repeat (N) @(posedge clk);
    @(negedge clk);
    check("R2", "first result", 32'(sel_mask), 32'h2A);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (N) @(posedge clk);
    @(negedge clk);
    check("R2", "waiting request result", 32'(sel_mask), 32'h04);

    // R1: reset while a ranking is running
    drive(3'd5, 1'b1, 1'b0, VA);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "mid reset mask", 32'(sel_mask), 32'd0);
    check("R1", "mid reset valid", 32'(mask_valid), 32'd0);
    check("R1", "mid reset ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    last_mask = '0;
    run_req(3'd2, 1'b0, 1'b0, VT, 6'h03, "R6");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule